// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the bus-facing register decoder of a multi-source interrupt controller. It accepts single-cycle 32-bit word reads and writes over an 18-bit byte offset (a 256 KB window) and sorts each access into one of four regions: global, timer, per-source and per-CPU. Three global registers live inside the block: a configuration word, a spurious vector and a timer-frequency word. Writing the configuration word with its top bit set raises a one-cycle controller reset pulse. Writing the processor-init word with bit 0 set raises a one-cycle CPU reset pulse.

Everything else is forwarded. Vector/priority and destination words of external sources, timers and inter-processor sources go to an external register array through a strobe port that carries a flat index. Timer count reads and base-count writes go to a timer port. Per-CPU accesses go to a CPU port with their region-relative offset. Read data from any target is captured one cycle after the read strobe. Misaligned or unmapped accesses are handled silently.

Top module: `irq_reg_frontend`

## Requirements
- R1: An access whose offset has any of bits 3:0 set raises no strobe, changes no stored register, and reads back 0xFFFFFFFF.
- R2: Offsets below 0x1100 are global, offsets from 0x1100 below 0x10000 are timer, offsets from 0x10000 below 0x20000 are source, and offsets from 0x20000 up are per-CPU; a per-CPU access presents offset bits 16:0 on `cpu_off`. Global words decode on offset bits 7:4 only.
- R3: A write to global word 0x20 stores bits 30:0 in `glb_cfg` and, when bit 31 is set, drives `ctl_reset` high for exactly the next cycle; bit 31 reads back as 0.
- R4: Global word 0xE0 keeps only data bits 7:0 (`spur_vec`); global word 0xF0 keeps all 32 bits (`tmr_freq`).
- R5: Global word 0x90 reads as 0; writing it with bit 0 set drives `cpu_reset` high for exactly the next cycle, and with bit 0 clear raises nothing.
- R6: Timer t sits at 0x1100 + 0x40*t. Sub-word 0x00 is its count (read-only: a write raises no strobe), 0x10 its base count (`tmr_sel`=1 on the timer port, count is `tmr_sel`=0), 0x20 and 0x30 are array index N_SRC+t with `arr_sel` 0 and 1.
- R7: Source s sits at 0x10000 + 0x20*s (index = offset bits 15:5); offset bit 4 clear selects the vector/priority word (`arr_sel`=0), set selects the destination word (`arr_sel`=1).
- R8: Global words 0xA0, 0xB0, 0xC0, 0xD0 map to inter-processor source k = (offset-0xA0)/16, array index N_SRC+N_TMR+k, `arr_sel`=0.
- R9: Aligned reads of unassigned global words, of timers with index at or above N_TMR and of sources with index at or above N_SRC return 0xFFFFFFFF and raise no strobe.
- R10: `rd_valid` is high in exactly the cycle after `bus_rd`, with `rd_data` holding the word addressed in the strobe cycle.
- R11: Synchronous reset clears all three stored words and both pulses; the clock edge that ends a `ctl_reset` cycle clears `spur_vec` and `tmr_freq` (not `glb_cfg`), except that a bus write landing in that same cycle takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 18 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| arr_wr | output | 1 | Register-array write strobe |
| arr_rd | output | 1 | Register-array read strobe |
| arr_idx | output | IDX_W | Flat array index (sources, then timers, then inter-processor) |
| arr_sel | output | 1 | 0 vector/priority, 1 destination |
| arr_rdata | input | 32 | Array read data, same cycle as `arr_rd` |
| tmr_wr | output | 1 | Timer base-count write strobe |
| tmr_rd | output | 1 | Timer read strobe |
| tmr_idx | output | TMR_W | Timer index |
| tmr_sel | output | 1 | 0 current count, 1 base count |
| tmr_rdata | input | 32 | Timer read data, same cycle as `tmr_rd` |
| cpu_wr | output | 1 | Per-CPU write strobe |
| cpu_rd | output | 1 | Per-CPU read strobe |
| cpu_off | output | 17 | Offset within the per-CPU region |
| cpu_rdata | input | 32 | Per-CPU read data, same cycle as `cpu_rd` |
| glb_cfg | output | 31 | Stored configuration bits 30:0 |
| spur_vec | output | 8 | Spurious vector |
| tmr_freq | output | 32 | Timer frequency word |
| ctl_reset | output | 1 | Controller reset pulse |
| cpu_reset | output | 1 | CPU reset request pulse |

## Verification
The soft clear that follows a controller reset pulse and an ordinary bus write to the spurious vector can land on the same clock edge. The bench writes the configuration word with bit 31 set and, in the very next cycle while `ctl_reset` is high, writes a new spurious vector; it then expects the written vector to survive while the timer-frequency word reads zero. A second pulse with an idle bus in its cycle must clear both words, and `glb_cfg` must keep the value stored by the triggering write in both cases.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int ADDR_W = 18;
  localparam logic [ADDR_W-1:0] TMR_BASE = 18'h01100;
  localparam logic [ADDR_W-1:0] SRC_BASE = 18'h10000;
  localparam logic [ADDR_W-1:0] CPU_BASE = 18'h20000;
  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  // Target of one decoded word access
  typedef enum logic [2:0] {
    TG_NONE,
    TG_GCFG,
    TG_PINIT,
    TG_SPUR,
    TG_TFREQ,
    TG_ARR,
    TG_TCNT,
    TG_CPU
  } tgt_e;
endpackage

// File: rtl/irqfe_decode.sv
module irqfe_decode
  import irqfe_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int N_TMR = 4,
  parameter int N_IPI = 4,
  parameter int IDX_W = 5,
  parameter int TMR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              sel,
  output logic [TMR_W-1:0]  t_idx,
  output logic              t_sel
);
  logic [15:0] t_off;
  logic [9:0]  t_num;
  logic [10:0] s_num;
  logic [3:0]  g_slot;
  logic [3:0]  ipi_k;

  assign t_off  = addr[15:0] - TMR_BASE[15:0];
  assign t_num  = t_off[15:6];
  assign s_num  = addr[15:5];
  assign g_slot = addr[7:4];
  assign ipi_k  = g_slot - 4'hA;

  logic unused_off;
  assign unused_off = ^t_off[3:0];

  always_comb begin
    tgt   = TG_NONE;
    idx   = '0;
    sel   = 1'b0;
    t_idx = '0;
    t_sel = 1'b0;
    if (addr[3:0] == 4'h0) begin
      if (addr < TMR_BASE) begin
        case (g_slot)
          4'h2: tgt = TG_GCFG;
          4'h9: tgt = TG_PINIT;
          4'hE: tgt = TG_SPUR;
          4'hF: tgt = TG_TFREQ;
          4'hA, 4'hB, 4'hC, 4'hD: begin
            if (int'(ipi_k) < N_IPI) begin
              tgt = TG_ARR;
              idx = IDX_W'(N_SRC + N_TMR) + IDX_W'(ipi_k);
            end
          end
          default: tgt = TG_NONE;
        endcase
      end else if (addr < SRC_BASE) begin
        if (int'(t_num) < N_TMR) begin
          t_idx = TMR_W'(t_num);
          case (t_off[5:4])
            2'd0: tgt = TG_TCNT;
            2'd1: begin tgt = TG_TCNT; t_sel = 1'b1; end
            2'd2: begin tgt = TG_ARR; idx = IDX_W'(N_SRC) + IDX_W'(t_num); end
            default: begin
              tgt = TG_ARR;
              idx = IDX_W'(N_SRC) + IDX_W'(t_num);
              sel = 1'b1;
            end
          endcase
        end
      end else if (addr < CPU_BASE) begin
        if (int'(s_num) < N_SRC) begin
          tgt = TG_ARR;
          idx = IDX_W'(s_num);
          sel = addr[4];
        end
      end else begin
        tgt = TG_CPU;
      end
    end
  end
endmodule

// File: rtl/irqfe_global_regs.sv
module irqfe_global_regs
  import irqfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  tgt_e        tgt,
  input  logic [31:0] wdata,
  output logic [30:0] cfg,
  output logic [7:0]  spur,
  output logic [31:0] tfreq,
  output logic        ctl_pulse,
  output logic        cpu_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      spur      <= '0;
      tfreq     <= '0;
      ctl_pulse <= 1'b0;
      cpu_pulse <= 1'b0;
    end else begin
      ctl_pulse <= wr && (tgt == TG_GCFG) && wdata[31];
      cpu_pulse <= wr && (tgt == TG_PINIT) && wdata[0];
      // soft clear first, so a write in the same cycle wins
      if (ctl_pulse) begin
        spur  <= '0;
        tfreq <= '0;
      end
      if (wr) begin
        case (tgt)
          TG_GCFG:  cfg   <= wdata[30:0];
          TG_SPUR:  spur  <= wdata[7:0];
          TG_TFREQ: tfreq <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqfe_read_path.sv
module irqfe_read_path
  import irqfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd,
  input  tgt_e        tgt,
  input  logic [30:0] cfg,
  input  logic [7:0]  spur,
  input  logic [31:0] tfreq,
  input  logic [31:0] arr_rdata,
  input  logic [31:0] tmr_rdata,
  input  logic [31:0] cpu_rdata,
  output logic [31:0] rdata,
  output logic        rvalid
);
  logic [31:0] mux;

  always_comb begin
    case (tgt)
      TG_GCFG:  mux = {1'b0, cfg};
      TG_PINIT: mux = '0;
      TG_SPUR:  mux = {24'h0, spur};
      TG_TFREQ: mux = tfreq;
      TG_ARR:   mux = arr_rdata;
      TG_TCNT:  mux = tmr_rdata;
      TG_CPU:   mux = cpu_rdata;
      default:  mux = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
    end
  end
endmodule

// File: rtl/irq_reg_frontend.sv
module irq_reg_frontend
  import irqfe_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int N_TMR = 4,
  parameter int N_IPI = 4,
  localparam int IDX_W = $clog2(N_SRC + N_TMR + N_IPI),
  localparam int TMR_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [17:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              arr_wr,
  output logic              arr_rd,
  output logic [IDX_W-1:0]  arr_idx,
  output logic              arr_sel,
  input  logic [31:0]       arr_rdata,
  output logic              tmr_wr,
  output logic              tmr_rd,
  output logic [TMR_W-1:0]  tmr_idx,
  output logic              tmr_sel,
  input  logic [31:0]       tmr_rdata,
  output logic              cpu_wr,
  output logic              cpu_rd,
  output logic [16:0]       cpu_off,
  input  logic [31:0]       cpu_rdata,
  output logic [30:0]       glb_cfg,
  output logic [7:0]        spur_vec,
  output logic [31:0]       tmr_freq,
  output logic              ctl_reset,
  output logic              cpu_reset
);
  tgt_e tgt;

  irqfe_decode #(
    .N_SRC(N_SRC), .N_TMR(N_TMR), .N_IPI(N_IPI), .IDX_W(IDX_W), .TMR_W(TMR_W)
  ) u_dec (
    .addr  (bus_addr),
    .tgt   (tgt),
    .idx   (arr_idx),
    .sel   (arr_sel),
    .t_idx (tmr_idx),
    .t_sel (tmr_sel)
  );

  assign arr_wr  = bus_wr && (tgt == TG_ARR);
  assign arr_rd  = bus_rd && (tgt == TG_ARR);
  assign tmr_wr  = bus_wr && (tgt == TG_TCNT) && tmr_sel;
  assign tmr_rd  = bus_rd && (tgt == TG_TCNT);
  assign cpu_wr  = bus_wr && (tgt == TG_CPU);
  assign cpu_rd  = bus_rd && (tgt == TG_CPU);
  assign cpu_off = bus_addr[16:0];

  irqfe_global_regs u_glb (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .tgt       (tgt),
    .wdata     (bus_wdata),
    .cfg       (glb_cfg),
    .spur      (spur_vec),
    .tfreq     (tmr_freq),
    .ctl_pulse (ctl_reset),
    .cpu_pulse (cpu_reset)
  );

  irqfe_read_path u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .tgt       (tgt),
    .cfg       (glb_cfg),
    .spur      (spur_vec),
    .tfreq     (tmr_freq),
    .arr_rdata (arr_rdata),
    .tmr_rdata (tmr_rdata),
    .cpu_rdata (cpu_rdata),
    .rdata     (rd_data),
    .rvalid    (rd_valid)
  );
endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [17:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        rd_valid,
  input logic        arr_wr,
  input logic        arr_rd,
  input logic        tmr_wr,
  input logic        tmr_rd,
  input logic        tmr_sel,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [7:0]  spur_vec,
  input logic [31:0] tmr_freq,
  input logic        ctl_reset,
  input logic        cpu_reset
);
  logic glb_hit;
  assign glb_hit = bus_addr < 18'h01100;

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[3:0] != 4'h0) |-> !(arr_wr || arr_rd || tmr_wr || tmr_rd || cpu_wr || cpu_rd)); // R1

  AST_ONE_WR_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_wr, tmr_wr, cpu_wr})); // R2

  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && glb_hit && bus_addr[7:0] == 8'h20 && bus_wdata[31]) |=> ctl_reset); // R3

  AST_CPU_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && glb_hit && bus_addr[7:0] == 8'h90 && bus_wdata[0]) |=> cpu_reset); // R5

  AST_COUNT_RO: assert property (@(posedge clk) disable iff (rst)
    tmr_wr |-> tmr_sel); // R6

  AST_RVALID_SET: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid); // R10

  AST_RVALID_CLR: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid); // R10

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl_reset && !bus_wr) |=> (spur_vec == 8'h0 && tmr_freq == 32'h0)); // R11
endmodule

bind irq_reg_frontend irqfe_checker u_chk (.*);

// File: tb/tb_irq_reg_frontend.sv
module tb_irq_reg_frontend;
  localparam int N_SRC = 16;
  localparam int N_TMR = 4;
  localparam int IDX_W = 5;
  localparam int TMR_W = 2;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd;
  logic [17:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic rd_valid;
  logic arr_wr, arr_rd, arr_sel;
  logic [IDX_W-1:0] arr_idx;
  logic [31:0] arr_rdata;
  logic tmr_wr, tmr_rd, tmr_sel;
  logic [TMR_W-1:0] tmr_idx;
  logic [31:0] tmr_rdata;
  logic cpu_wr, cpu_rd;
  logic [16:0] cpu_off;
  logic [31:0] cpu_rdata;
  logic [30:0] glb_cfg;
  logic [7:0] spur_vec;
  logic [31:0] tmr_freq;
  logic ctl_reset, cpu_reset;

  always #2 clk = ~clk;

  // responders: data encodes which target and index was reached
  assign arr_rdata = 32'hA000_0000 | (32'(arr_sel) << 16) | 32'(arr_idx);
  assign tmr_rdata = 32'hB000_0000 | (32'(tmr_sel) << 16) | 32'(tmr_idx);
  assign cpu_rdata = 32'hC000_0000 | 32'(cpu_off);

  irq_reg_frontend dut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // strobe snapshot from the last write
  logic s_arr_wr, s_arr_sel, s_tmr_wr, s_tmr_sel, s_cpu_wr;
  logic [IDX_W-1:0] s_arr_idx;
  logic [TMR_W-1:0] s_tmr_idx;
  logic [16:0] s_cpu_off;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [17:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    s_arr_wr = arr_wr; s_arr_sel = arr_sel; s_arr_idx = arr_idx;
    s_tmr_wr = tmr_wr; s_tmr_sel = tmr_sel; s_tmr_idx = tmr_idx;
    s_cpu_wr = cpu_wr; s_cpu_off = cpu_off;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [17:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [17:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset_state;
    check("R11 reset cfg", 32'(glb_cfg), 0);
    check("R11 reset spur", 32'(spur_vec), 0);
    check("R11 reset tfreq", tmr_freq, 0);
    check("R11 reset pulses", {30'd0, ctl_reset, cpu_reset}, 0);
    check("R10 reset rd_valid", 32'(rd_valid), 0);
  endtask

  task automatic t_misaligned;
    bus_write(18'h20024, 32'h1);
    check("R1 misaligned cpu write strobe", 32'(s_cpu_wr), 0);
    bus_write(18'h000E4, 32'h55);
    check("R1 misaligned spur unchanged", 32'(spur_vec), 0);
    rd_chk("R1 misaligned global read", 18'h00028, 32'hFFFF_FFFF);
    rd_chk("R1 misaligned source read", 18'h10008, 32'hFFFF_FFFF);
  endtask

  task automatic t_globals;
    bus_write(18'h000E0, 32'h0000_01AB);
    check("R4 spur port", 32'(spur_vec), 32'hAB);
    rd_chk("R4 spur read", 18'h000E0, 32'hAB);
    bus_write(18'h000F0, 32'hDEAD_BEEF);
    rd_chk("R4 tfreq read", 18'h000F0, 32'hDEAD_BEEF);
    rd_chk("R2 global alias 0x10F0", 18'h010F0, 32'hDEAD_BEEF);
    rd_chk("R9 global word 0x00", 18'h00000, 32'hFFFF_FFFF);
    rd_chk("R9 global word 0x80", 18'h00080, 32'hFFFF_FFFF);
  endtask

  task automatic t_pinit;
    rd_chk("R5 pinit reads 0", 18'h00090, 32'h0);
    bus_write(18'h00090, 32'h2);
    check("R5 no pulse bit0 clear", 32'(cpu_reset), 0);
    bus_write(18'h00090, 32'h1);
    check("R5 pulse high", 32'(cpu_reset), 1);
    @(negedge clk);
    check("R5 pulse one cycle", 32'(cpu_reset), 0);
  endtask

  task automatic t_regions;
    rd_chk("R2 timer region start", 18'h01100, 32'hB000_0000);
    rd_chk("R2 source region start", 18'h10000, 32'hA000_0000);
    rd_chk("R2 cpu region start", 18'h20000, 32'hC000_0000);
    rd_chk("R2 cpu region top", 18'h3FFF0, 32'hC001_FFF0);
    bus_write(18'h20450, 32'h7);
    check("R2 cpu write strobe", 32'(s_cpu_wr), 1);
    check("R2 cpu write offset", 32'(s_cpu_off), 32'h00450);
  endtask

  task automatic t_timers;
    rd_chk("R6 timer3 base read", 18'h011D0, 32'hB001_0003);
    bus_write(18'h011C0, 32'h9);
    check("R6 count write ignored", {30'd0, s_tmr_wr, s_arr_wr}, 0);
    bus_write(18'h01190, 32'h9);
    check("R6 base write strobe", 32'(s_tmr_wr), 1);
    check("R6 base write index", 32'(s_tmr_idx), 2);
    bus_write(18'h011A0, 32'h9);
    check("R6 timer vecpri strobe", {30'd0, s_arr_wr, s_arr_sel}, 32'h2);
    check("R6 timer vecpri index", 32'(s_arr_idx), N_SRC + 2);
    rd_chk("R6 timer1 dest read", 18'h01170, 32'hA001_0011);
    rd_chk("R9 timer index 4", 18'h01200, 32'hFFFF_FFFF);
  endtask

  task automatic t_sources;
    rd_chk("R7 source1 dest read", 18'h10030, 32'hA001_0001);
    bus_write(18'h101E0, 32'h3);
    check("R7 source15 vecpri strobe", {30'd0, s_arr_wr, s_arr_sel}, 32'h2);
    check("R7 source15 index", 32'(s_arr_idx), 15);
    rd_chk("R9 source index 16", 18'h10200, 32'hFFFF_FFFF);
    rd_chk("R9 source top", 18'h1FFF0, 32'hFFFF_FFFF);
  endtask

  task automatic t_ipi;
    rd_chk("R8 ipi1 read", 18'h000B0, 32'hA000_0015);
    bus_write(18'h000D0, 32'h4);
    check("R8 ipi3 write strobe", {30'd0, s_arr_wr, s_arr_sel}, 32'h2);
    check("R8 ipi3 index", 32'(s_arr_idx), 23);
  endtask

  task automatic t_cfg_reset;
    bus_write(18'h000F0, 32'h1234_5678);
    bus_write(18'h00020, 32'h8000_0012);
    check("R3 ctl pulse high", 32'(ctl_reset), 1);
    check("R3 cfg stored", 32'(glb_cfg), 32'h12);
    // write lands in the pulse cycle
    bus_write(18'h000E0, 32'h33);
    check("R11 write beats soft clear", 32'(spur_vec), 32'h33);
    check("R11 tfreq cleared", tmr_freq, 0);
    check("R3 ctl pulse one cycle", 32'(ctl_reset), 0);
    rd_chk("R3 cfg bit31 reads 0", 18'h00020, 32'h12);
    bus_write(18'h000F0, 32'hCAFE_0001);
    bus_write(18'h00020, 32'h8000_0005);
    @(negedge clk);
    check("R11 idle soft clear spur", 32'(spur_vec), 0);
    check("R11 idle soft clear tfreq", tmr_freq, 0);
    check("R11 cfg kept", 32'(glb_cfg), 32'h5);
  endtask

  task automatic t_rvalid;
    logic [31:0] d;
    bus_read(18'h000E0, d);
    @(negedge clk);
    check("R10 rd_valid drops", 32'(rd_valid), 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_misaligned();
    t_globals();
    t_pinit();
    t_regions();
    t_timers();
    t_sources();
    t_ipi();
    t_cfg_reset();
    t_rvalid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule